// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel for PIO and multiword DMA transfers. Each attached device has its own 32-bit timing word. The word holds one set of strobe widths for data transfers and a second set for task-file register accesses. Every width is counted in clock cycles.

The controller issues one bus cycle at a time. Each request carries a channel number, a device number, a direction, a flag that marks a task-file (command) access, and a flag that marks the first cycle of a burst. The block selects the timing word for the addressed device and captures the word when it accepts the request. It then inserts a setup gap if the first-of-burst flag is set. Next it holds the strobe low for the active time and high for the recovery time, and finally it raises a one-cycle done pulse.

The timing words are written through a simple write port. The upper four bits of each word, which hold transfer-mode enables, are stored but do not affect strobe generation.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, both strobes are high, `reqReady` is 1, and `cycDone` is 0. Every timing word holds `RESET_WORD` (default 0x0120A7A7).
- R2: The strobe stays low for field+1 clock cycles. The field is bits [8:4] for a data access (`reqCmd`=0) and bits [17:13] for a command access (`reqCmd`=1).
- R3: After the active phase, both strobes stay high for field+1 cycles before the done pulse. The field is bits [3:0] for a data access and bits [12:9] for a command access.
- R4: When `reqFirst`=1, both strobes stay high for field+1 cycles after the acceptance edge, before the active phase. The field is bits [24:22] for a data access and bits [27:25] for a command access. When `reqFirst`=0, the active phase starts in the first cycle after acceptance.
- R5: A read (`reqWrite`=0) lowers only `diorN`, and a write (`reqWrite`=1) lowers only `diowN`. The two strobes are never low together.
- R6: `cycDone` is high for exactly one cycle, directly after the recovery phase. In the next cycle `reqReady` is 1 again.
- R7: A request is accepted only on an edge where `reqReady` is 1. A `reqValid` seen while busy is ignored: it does not change the cycle in progress and does not start another cycle.
- R8: The timing word used is the word at index `reqDev` + 2×`reqChan`. `regWrEn` writes `regWrData` to index `regWrIdx`.
- R9: The timing word is captured on the acceptance edge. A write to that word during a cycle changes only later requests.
- R10: A field value of zero still gives a one-cycle phase. An all-ones word gives 8 setup, 32 active and 16 recovery cycles on a first data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Timing word write enable |
| regWrIdx | input | CH_W+1 | Index of the timing word to write |
| regWrData | input | 32 | New timing word |
| reqValid | input | 1 | Request for one bus cycle |
| reqChan | input | CH_W | Channel of the request |
| reqDev | input | 1 | Device number within the channel |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqCmd | input | 1 | 1 = task-file register access, 0 = data access |
| reqFirst | input | 1 | First cycle of a burst; adds the setup phase |
| reqReady | output | 1 | Block is idle and will accept a request |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| cycDone | output | 1 | One-cycle pulse at the end of a bus cycle |

## Verification
The hardest case to reach is a change to the device's timing word that lands while that device's strobe is already low. The bench handles this by detecting the first sampled low strobe and writing a fresh random word to the same index in that cycle. It then checks that the current cycle keeps the old widths and that the next request to that device uses the new ones.

In the same cycle the bench raises a request of the opposite direction, to show that it is ignored. Random words, devices and flags are mixed with all-zero and all-ones words to cover both extremes of every field.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

  localparam int TIM_W = 32;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    LD_SETUP = 2'd0,
    LD_LOW   = 2'd1,
    LD_HIGH  = 2'd2
  } loadSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     load;
    loadSel_e sel;
    logic     dec;
    logic     strobeOn;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [2:0] setup;
    logic [4:0] low;
    logic [3:0] high;
  } phaseFields_t;

  function automatic phaseFields_t pickFields(input logic [TIM_W-1:0] w, input logic isCmd);
    phaseFields_t f;
    if (isCmd) begin
      f.setup = w[27:25];
      f.low   = w[17:13];
      f.high  = w[12:9];
    end else begin
      f.setup = w[24:22];
      f.low   = w[8:4];
      f.high  = w[3:0];
    end
    return f;
  endfunction

endpackage

// File: rtl/pio_timing_bank.sv
module pio_timing_bank
  import pio_strobe_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 2,
  parameter logic [TIM_W-1:0] RESET_WORD = 32'h0120A7A7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TIM_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [TIM_W-1:0] rdData
);

  logic [TIM_W-1:0] words [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        words[i] <= RESET_WORD;
      end else if (wrEn && (wrIdx == IDX_W'(i))) begin
        words[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = RESET_WORD;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdIdx == IDX_W'(i)) rdData = words[i];
    end
  end

endmodule

// File: rtl/pio_strobe_dp.sv
module pio_strobe_dp
  import pio_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctl,
  input  logic [TIM_W-1:0] liveWord,
  input  logic             liveCmd,
  input  logic             liveWrite,
  output logic             cntZero,
  output logic             diorN,
  output logic             diowN
);

  phaseFields_t latF, srcF;
  logic         latWrite;
  logic [CNT_W-1:0] cnt;

  // on the accept edge the fields come straight from the bank
  assign srcF = ctl.capture ? pickFields(liveWord, liveCmd) : latF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latF     <= '0;
      latWrite <= 1'b0;
    end else if (ctl.capture) begin
      latF     <= srcF;
      latWrite <= liveWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      case (ctl.sel)
        LD_SETUP: cnt <= CNT_W'(srcF.setup);
        LD_HIGH:  cnt <= CNT_W'(srcF.high);
        default:  cnt <= CNT_W'(srcF.low);
      endcase
    end else if (ctl.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign diorN   = ~(ctl.strobeOn & ~latWrite);
  assign diowN   = ~(ctl.strobeOn &  latWrite);

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (diorN || diowN));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.strobeOn |-> (cnt <= CNT_W'(latF.low)));

endmodule

// File: rtl/pio_strobe_ctrl.sv
module pio_strobe_ctrl
  import pio_strobe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqFirst,
  input  logic         cntZero,
  output ctrlStrobes_t ctl,
  output logic         reqReady,
  output logic         cycDone
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOVER, ST_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    ctl.sel   = LD_LOW;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          ctl.load    = 1'b1;
          if (reqFirst) begin
            ctl.sel   = LD_SETUP;
            nextState = ST_SETUP;
          end else begin
            nextState = ST_ACTIVE;
          end
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          ctl.load  = 1'b1;
          nextState = ST_ACTIVE;
        end else ctl.dec = 1'b1;
      end
      ST_ACTIVE: begin
        ctl.strobeOn = 1'b1;
        if (cntZero) begin
          ctl.load  = 1'b1;
          ctl.sel   = LD_HIGH;
          nextState = ST_RECOVER;
        end else ctl.dec = 1'b1;
      end
      ST_RECOVER: begin
        if (cntZero) nextState = ST_DONE;
        else         ctl.dec = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign cycDone  = (state == ST_DONE);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> (!cycDone && reqReady));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_setup_to_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && cntZero) |=> ctl.strobeOn);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int NUM_CHAN = 2,
  parameter logic [31:0] RESET_WORD = 32'h0120A7A7,
  localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
  localparam int IDX_W = CH_W + 1,
  localparam int NUM_REGS = 2 * NUM_CHAN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  input  logic [31:0]      regWrData,
  input  logic             reqValid,
  input  logic [CH_W-1:0]  reqChan,
  input  logic             reqDev,
  input  logic             reqWrite,
  input  logic             reqCmd,
  input  logic             reqFirst,
  output logic             reqReady,
  output logic             diorN,
  output logic             diowN,
  output logic             cycDone
);

  ctrlStrobes_t     ctl;
  logic             cntZero;
  logic [TIM_W-1:0] liveWord;
  logic [IDX_W-1:0] rdIdx;

  // index = device + 2 * channel
  assign rdIdx = {reqChan, reqDev};

  pio_timing_bank #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RESET_WORD(RESET_WORD)
  ) u_bank (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrIdx(regWrIdx),
    .wrData(regWrData), .rdIdx(rdIdx), .rdData(liveWord)
  );

  pio_strobe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFirst(reqFirst),
    .cntZero(cntZero), .ctl(ctl), .reqReady(reqReady), .cycDone(cycDone)
  );

  pio_strobe_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .liveWord(liveWord),
    .liveCmd(reqCmd), .liveWrite(reqWrite), .cntZero(cntZero),
    .diorN(diorN), .diowN(diowN)
  );

  assert_recover_before_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(diorN && diowN) |-> !cycDone);

endmodule

// File: tb/pio_strobe_gen_bench.sv
`timescale 1ns/1ps
module pio_strobe_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrIdx = '0;
  logic [31:0] regWrData = '0;
  logic reqValid = 1'b0;
  logic [0:0] reqChan = '0;
  logic reqDev = 1'b0, reqWrite = 1'b0, reqCmd = 1'b0, reqFirst = 1'b0;
  logic reqReady, diorN, diowN, cycDone;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] model [4];

  always #2.5 clk = ~clk;

  pio_strobe_gen u_pio_strobe_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .reqValid(reqValid), .reqChan(reqChan),
    .reqDev(reqDev), .reqWrite(reqWrite), .reqCmd(reqCmd), .reqFirst(reqFirst),
    .reqReady(reqReady), .diorN(diorN), .diowN(diowN), .cycDone(cycDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expSetup(input logic [31:0] w, input bit cmd, input bit first);
    if (!first) return 0;
    return cmd ? int'(w[27:25]) + 1 : int'(w[24:22]) + 1;
  endfunction
  function automatic int expLow(input logic [31:0] w, input bit cmd);
    return cmd ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
  endfunction
  function automatic int expHigh(input logic [31:0] w, input bit cmd);
    return cmd ? int'(w[12:9]) + 1 : int'(w[3:0]) + 1;
  endfunction

  task automatic writeReg(input int idx, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrIdx = 2'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    model[idx] = d;
  endtask

  task automatic runCycle(input int chan, input int dev, input bit wr, input bit cmd,
                          input bit first, input bit midWr, input logic [31:0] midData,
                          input bit poke);
    int idx = dev + 2 * chan;
    logic [31:0] w = model[idx];
    int pre = 0, low = 0, post = 0, wrong = 0, guard = 0, phase = 0;
    bit doneSeen = 0, injected = 0;
    @(negedge clk);
    chk("R7 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqChan = 1'(chan); reqDev = 1'(dev);
    reqWrite = wr; reqCmd = cmd; reqFirst = first;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneSeen && guard < 200) begin
      guard++;
      if (cycDone) begin
        doneSeen = 1;
        chk("R6 strobes high at done", int'(diorN && diowN), 1);
      end else if (!diorN || !diowN) begin
        low++; phase = 1;
        if (wr ? !diorN : !diowN) wrong++;
        if (!injected) begin
          injected = 1;
          if (midWr) begin
            regWrEn = 1'b1; regWrIdx = 2'(idx); regWrData = midData;
          end
          if (poke) begin
            reqValid = 1'b1; reqWrite = ~wr; reqFirst = 1'b1; reqCmd = ~cmd;
          end
        end
      end else if (phase == 0) pre++;
      else post++;
      if (!doneSeen) begin
        @(negedge clk);
        regWrEn = 1'b0; reqValid = 1'b0;
      end
    end
    chk("R6 done pulse seen", int'(doneSeen), 1);
    chk("R4 setup cycles", pre, expSetup(w, cmd, first));
    chk(cmd ? "R2 cmd active cycles" : "R2 data active cycles", low, expLow(w, cmd));
    chk(cmd ? "R3 cmd recovery cycles" : "R3 data recovery cycles", post, expHigh(w, cmd));
    chk("R5 wrong strobe low", wrong, 0);
    @(negedge clk);
    chk("R6 ready after done", int'(reqReady && !cycDone), 1);
    if (midWr) model[idx] = midData;
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        chk("R7 busy request ignored", int'(diorN && diowN && reqReady), 1);
        @(negedge clk);
      end
    end
  endtask

  task automatic mainFlow();
    for (int i = 0; i < 4; i++) model[i] = 32'h0120A7A7;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 read strobe idle", int'(diorN), 1);
    chk("R1 write strobe idle", int'(diowN), 1);
    chk("R1 ready", int'(reqReady), 1);
    chk("R1 done low", int'(cycDone), 0);
    // R1 reset words on every device, data and command
    for (int i = 0; i < 4; i++) begin
      runCycle(i / 2, i % 2, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
      runCycle(i / 2, i % 2, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    end
    // R10 extremes
    writeReg(1, 32'h0);
    runCycle(0, 1, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    runCycle(0, 1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    writeReg(2, 32'hFFFF_FFFF);
    runCycle(1, 0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    runCycle(1, 0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    // R8 distinct words per device
    writeReg(0, 32'h0A40_2013); writeReg(1, 32'h0240_4F25);
    writeReg(2, 32'h0C80_6031); writeReg(3, 32'h0E02_8447);
    for (int i = 0; i < 4; i++) runCycle(i / 2, i % 2, 1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    // R9 mid-cycle write, then next request uses new word
    runCycle(1, 1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00C0_0052, 1'b0);
    runCycle(1, 1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    // R7 request while busy
    runCycle(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    // random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 150; n++) begin
      int c = int'($urandom % 2);
      int d = int'($urandom % 2);
      if ($urandom % 4 == 0) writeReg(int'($urandom % 4), $urandom);
      runCycle(c, d, 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 5 == 0), $urandom, ($urandom % 6 == 0));
    end
  endtask

  initial begin
    bit timedOut = 0;
    fork
      mainFlow();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule